// File: doc/BRIEF.md
# Interrupt Service Sequencer

This block services the active-low interrupt line of a peripheral that is reached through a serial register bus. It does not move bits on the wire itself. It issues one register access at a time on a plain request port (address, write data, direction, request) and waits for a separate transport engine to answer with done, an error flag and read data.

A falling edge on the interrupt line starts a service pass. A pass is also pending straight out of reset, so an event raised before the edge detector existed is not lost. In each pass the sequencer reads the peripheral's interrupt register and writes back only the bits that are allowed to be cleared. When the serial-bus error flag is set, it reads the status register and clears the clearable status bits. When the CAN-core flag is set, it pulses two downstream service strobes, line 0 first and line 1 next. It then reads the interrupt register again and keeps looping until that register reads zero.

Top module: `irq_service_seq`

## Requirements
- R1: After a synchronous active-high reset, no request is raised and both strobes are low. One service pass is pending, so the first access after reset is a read of the interrupt register at 0x0820, even when the interrupt line never fell.
- R2: A pass starts only on a high-to-low transition of `irq_n`. A steady low level or a rising edge starts nothing.
- R3: A pass begins with a read of the interrupt register. When that read returns zero, the block goes back to idle and issues no further access.
- R4: After a non-zero interrupt read, the block writes to 0x0820 the value read ANDed with 0x00FDE500. That mask covers bits 8, 10, 13 to 16 and 18 to 23.
- R5: When bit 3 of the interrupt value is set, the interrupt write-back is followed by a read of the status register at 0x000C. That read is followed by a write to 0x000C of the value read ANDed with 0x3F3F0000.
- R6: When bit 1 of the interrupt value is set, `svc0_stb` pulses for one cycle. `svc1_stb` pulses in the cycle after it. Both come after any status handling, and no request is raised while a strobe is high.
- R7: After the handling steps, the interrupt register is read again. A non-zero value repeats the write-back and handling steps with the new value. A zero value ends the loop.
- R8: An error answer on an interrupt-register read or write ends the loop at once. No further access follows until a new pass is triggered.
- R9: An error answer on the status read or on the status write makes the block rewrite the interrupt register with the same cleared value. Handling then continues from that point.
- R10: A falling edge seen while a loop is running is held as a single pending event, however many edges arrive. It starts exactly one more pass after the loop ends.
- R11: Only one access is outstanding at a time. `acc_req`, `acc_we`, `acc_addr` and `acc_wdata` hold steady until `acc_done` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 1 | Peripheral interrupt line, active low, synchronous to clk |
| acc_req | output | 1 | Register access request, held until done |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | AW (16) | Register address |
| acc_wdata | output | DW (32) | Write data |
| acc_done | input | 1 | One-cycle completion of the current access |
| acc_err | input | 1 | Completion carries an error, valid with acc_done |
| acc_rdata | input | DW (32) | Read data, valid with acc_done |
| svc0_stb | output | 1 | Line 0 service strobe |
| svc1_stb | output | 1 | Line 1 service strobe |

## Verification
The hardest situation to reach from the ports is a second and a third falling edge of the interrupt line that land while an access of the first pass is still outstanding. The edges must then collapse into exactly one extra pass. The bench slows its transport responder to eight cycles per access, so that two short pulses of `irq_n` fit inside a single pending read. The same scripted responder injects error answers on chosen accesses. This steers the loop into its status-retry path and its early-exit path, which a well-behaved peripheral would never take.

// File: rtl/irq_service_seq.sv
module irq_service_seq #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] IR_ADDR = 16'h0820,
  parameter logic [AW-1:0] ST_ADDR = 16'h000C,
  parameter logic [DW-1:0] IR_CLR = 32'h00FD_E500,
  parameter logic [DW-1:0] ST_CLR = 32'h3F3F_0000,
  parameter int BUSERR_BIT = 3,
  parameter int CORE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_n,
  output logic          acc_req,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic          acc_done,
  input  logic          acc_err,
  input  logic [DW-1:0] acc_rdata,
  output logic          svc0_stb,
  output logic          svc1_stb
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_IR, S_WR_IR, S_RD_ST, S_WR_ST, S_SVC0, S_SVC1
  } state_t;

  state_t        state;
  logic          irq_q;
  logic          pend;
  logic [DW-1:0] ir_val;
  logic [DW-1:0] st_val;
  logic          fall;

  assign fall = irq_q & ~irq_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      irq_q  <= 1'b1;
      pend   <= 1'b1;
      ir_val <= '0;
      st_val <= '0;
    end else begin
      irq_q <= irq_n;
      if (state == S_IDLE && pend) pend <= fall;
      else if (fall)               pend <= 1'b1;

      case (state)
        S_IDLE: if (pend) state <= S_RD_IR;
        S_RD_IR: if (acc_done) begin
          if (acc_err || acc_rdata == '0) state <= S_IDLE;
          else begin
            ir_val <= acc_rdata;
            state  <= S_WR_IR;
          end
        end
        S_WR_IR: if (acc_done) begin
          if (acc_err)                state <= S_IDLE;
          else if (ir_val[BUSERR_BIT]) state <= S_RD_ST;
          else if (ir_val[CORE_BIT])   state <= S_SVC0;
          else                         state <= S_RD_IR;
        end
        S_RD_ST: if (acc_done) begin
          if (acc_err) state <= S_WR_IR;
          else begin
            st_val <= acc_rdata;
            state  <= S_WR_ST;
          end
        end
        S_WR_ST: if (acc_done) begin
          if (acc_err)               state <= S_WR_IR;
          else if (ir_val[CORE_BIT]) state <= S_SVC0;
          else                       state <= S_RD_IR;
        end
        S_SVC0:  state <= S_SVC1;
        S_SVC1:  state <= S_RD_IR;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign acc_req   = (state == S_RD_IR) || (state == S_WR_IR) ||
                     (state == S_RD_ST) || (state == S_WR_ST);
  assign acc_we    = (state == S_WR_IR) || (state == S_WR_ST);
  assign acc_addr  = (state == S_RD_ST || state == S_WR_ST) ? ST_ADDR :
                     (state == S_RD_IR || state == S_WR_IR) ? IR_ADDR : '0;
  assign acc_wdata = (state == S_WR_IR) ? (ir_val & IR_CLR) :
                     (state == S_WR_ST) ? (st_val & ST_CLR) : '0;
  assign svc0_stb  = (state == S_SVC0);
  assign svc1_stb  = (state == S_SVC1);

endmodule

// File: rtl/irq_service_seq_chk.sv
module irq_service_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] IR_ADDR = 16'h0820,
  parameter logic [AW-1:0] ST_ADDR = 16'h000C,
  parameter logic [DW-1:0] IR_CLR = 32'h00FD_E500,
  parameter logic [DW-1:0] ST_CLR = 32'h3F3F_0000
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_req,
  input logic          acc_we,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_wdata,
  input logic          acc_done,
  input logic          acc_err,
  input logic [DW-1:0] acc_rdata,
  input logic          svc0_stb,
  input logic          svc1_stb
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !acc_req && !svc0_stb && !svc1_stb);

  p_ir_write_mask_r4: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_we && acc_addr == IR_ADDR |-> (acc_wdata & ~IR_CLR) == '0);

  p_st_write_mask_r5: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_we && acc_addr == ST_ADDR |-> (acc_wdata & ~ST_CLR) == '0);

  p_strobe_order_r6: assert property (@(posedge clk) disable iff (rst)
    svc0_stb |=> svc1_stb);

  p_strobe_follow_r6: assert property (@(posedge clk) disable iff (rst)
    svc1_stb |-> $past(svc0_stb));

  p_strobe_alone_r6: assert property (@(posedge clk) disable iff (rst)
    (svc0_stb || svc1_stb) |-> !acc_req && !(svc0_stb && svc1_stb));

  p_reread_r7: assert property (@(posedge clk) disable iff (rst)
    svc1_stb |=> acc_req && !acc_we && acc_addr == IR_ADDR);

  p_ir_exit_r8: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_done && acc_addr == IR_ADDR &&
    (acc_err || (!acc_we && acc_rdata == '0)) |=> !acc_req);

  p_st_retry_r9: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_done && acc_err && acc_addr == ST_ADDR
    |=> acc_req && acc_we && acc_addr == IR_ADDR);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    acc_req && !acc_done |=> acc_req && $stable(acc_we) &&
    $stable(acc_addr) && $stable(acc_wdata));

endmodule

bind irq_service_seq irq_service_seq_chk #(
  .AW(AW), .DW(DW), .IR_ADDR(IR_ADDR), .ST_ADDR(ST_ADDR),
  .IR_CLR(IR_CLR), .ST_CLR(ST_CLR)
) u_chk (
  .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_done(acc_done),
  .acc_err(acc_err), .acc_rdata(acc_rdata), .svc0_stb(svc0_stb),
  .svc1_stb(svc1_stb)
);

// File: tb/tb_irq_service_seq.sv
module tb_irq_service_seq;
  localparam logic [15:0] IR_A = 16'h0820;
  localparam logic [15:0] ST_A = 16'h000C;
  localparam logic [31:0] IR_M = 32'h00FD_E500;
  localparam logic [31:0] ST_M = 32'h3F3F_0000;

  logic clk = 1'b0, rst = 1'b1, irq_n = 1'b1;
  logic acc_req, acc_we, svc0_stb, svc1_stb;
  logic [15:0] acc_addr;
  logic [31:0] acc_wdata;
  logic acc_done = 1'b0, acc_err = 1'b0;
  logic [31:0] acc_rdata = '0;

  always #10 clk = ~clk;

  irq_service_seq dut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_done(acc_done),
    .acc_err(acc_err), .acc_rdata(acc_rdata), .svc0_stb(svc0_stb),
    .svc1_stb(svc1_stb)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string scen = "R1";
  int lat = 1;

  // entry: {kind[1:0], we, addr[15:0], data[31:0]}; kind 0 access, 1 strobe pair
  logic [50:0] expq[$];
  logic [31:0] scr_d[$], rsp_d[$];
  bit          scr_e[$], rsp_e[$];

  function void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: actual %h expected %h", req, scen, act, exp);
    end
  endfunction

  function string tag_of(logic [50:0] x);
    if (x[50:49] == 2'd1) return "R6";
    if (x[47:32] == ST_A) return "R5";
    if (x[48])            return "R4";
    return "R7";
  endfunction

  task automatic add_rsp(logic [31:0] d, bit e);
    scr_d.push_back(d); scr_e.push_back(e);
    rsp_d.push_back(d); rsp_e.push_back(e);
  endtask

  // Behavioural reference: walks the scripted answers in access order
  task automatic build(int passes);
    for (int p = 0; p < passes; p++) begin
      logic [31:0] ir, d;
      bit e, go;
      expq.push_back({2'd0, 1'b0, IR_A, 32'h0});
      d = scr_d.pop_front(); e = scr_e.pop_front();
      go = !e && d != 0; ir = d;
      while (go) begin
        expq.push_back({2'd0, 1'b1, IR_A, ir & IR_M});
        d = scr_d.pop_front(); e = scr_e.pop_front();
        if (e) go = 0;
        else begin
          bit redo;
          redo = 0;
          if (ir[3]) begin
            expq.push_back({2'd0, 1'b0, ST_A, 32'h0});
            d = scr_d.pop_front(); e = scr_e.pop_front();
            if (e) redo = 1;
            else begin
              expq.push_back({2'd0, 1'b1, ST_A, d & ST_M});
              d = scr_d.pop_front(); e = scr_e.pop_front();
              if (e) redo = 1;
            end
          end
          if (!redo) begin
            if (ir[1]) expq.push_back({2'd1, 1'b0, 16'h0, 32'h0});
            expq.push_back({2'd0, 1'b0, IR_A, 32'h0});
            d = scr_d.pop_front(); e = scr_e.pop_front();
            if (e || d == 0) go = 0; else ir = d;
          end
        end
      end
    end
  endtask

  // Transport responder and per-clock comparison
  bit busy = 0, want1 = 0;
  int cnt = 0;
  logic [15:0] h_addr;
  logic h_we;
  logic [31:0] h_wd;

  always @(negedge clk) begin
    if (!rst) begin
      if (want1) begin
        chk(svc1_stb, "R6", {63'h0, svc1_stb}, 64'h1);
        want1 = 0;
      end else if (svc1_stb) chk(0, "R6", 64'h1, 64'h0);
      if (svc0_stb) begin
        if (expq.size() != 0 && expq[0][50:49] == 2'd1) begin
          chk(1, "R6", 64'h1, 64'h1);
          void'(expq.pop_front());
        end else chk(0, "R6", 64'h1, 64'h0);
        want1 = 1;
      end
      if (acc_done) begin
        acc_done = 0; acc_err = 0;
      end else if (busy) begin
        chk(acc_req && acc_addr == h_addr && acc_we == h_we && acc_wdata == h_wd, "R11",
            {acc_req, acc_we, acc_addr, acc_wdata}, {1'b1, h_we, h_addr, h_wd});
        if (cnt == 0) begin
          acc_rdata = rsp_d.pop_front();
          acc_err   = rsp_e.pop_front();
          acc_done  = 1;
          busy      = 0;
        end else cnt--;
      end else if (acc_req) begin
        if (expq.size() == 0 || expq[0][50:49] != 2'd0) begin
          chk(0, "R3", {acc_we, acc_addr, acc_wdata}, 64'h0);
        end else begin
          logic [50:0] x;
          x = expq.pop_front();
          chk(acc_we == x[48] && acc_addr == x[47:32] && (!x[48] || acc_wdata == x[31:0]),
              tag_of(x), {acc_we, acc_addr, acc_wdata}, {x[48], x[47:32], x[31:0]});
        end
        busy = 1; cnt = lat;
        h_addr = acc_addr; h_we = acc_we; h_wd = acc_wdata;
      end
    end
  end

  task automatic wait_idle(string req);
    int t;
    bit quiet;
    t = 0;
    while ((expq.size() != 0 || busy || acc_done) && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(t < 3000, req, t, 3000);
    quiet = 1;
    repeat (12) begin
      @(negedge clk);
      if (acc_req || svc0_stb || svc1_stb) quiet = 0;
    end
    chk(quiet && rsp_d.size() == 0, req, {acc_req, rsp_d.size()}, 64'h0);
  endtask

  task automatic trigger();
    irq_n = 1'b1;
    repeat (3) @(negedge clk);
    irq_n = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog [%s]: actual hung expected idle", scen);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!acc_req && !svc0_stb && !svc1_stb, "R1", {acc_req, svc0_stb, svc1_stb}, 64'h0);

    // R1: start-up pass without any edge
    scen = "R1";
    add_rsp(32'h0, 0);
    build(1);
    rst = 1'b0;
    wait_idle("R1");

    // R2 R3 R4 R7: two-round loop, non-clearable bit 31 masked off
    scen = "R2 R3 R4 R7";
    add_rsp(32'h8000_0100, 0); add_rsp(0, 0);
    add_rsp(32'h0000_2000, 0); add_rsp(0, 0);
    add_rsp(32'h0, 0);
    build(1);
    trigger();
    wait_idle("R2");

    // R5 R6: bus error flag plus core flag
    scen = "R5 R6";
    add_rsp(32'h0040_000A, 0); add_rsp(0, 0);
    add_rsp(32'hFFFF_FFFF, 0); add_rsp(0, 0);
    add_rsp(32'h0, 0);
    build(1);
    trigger();
    wait_idle("R5");

    // R6: core flag alone
    scen = "R6";
    add_rsp(32'h0000_0002, 0); add_rsp(0, 0); add_rsp(32'h0, 0);
    build(1);
    trigger();
    wait_idle("R6");

    // R8: error on the interrupt write, then on the interrupt read
    scen = "R8";
    add_rsp(32'h0000_0100, 0); add_rsp(0, 1);
    build(1);
    trigger();
    wait_idle("R8");
    add_rsp(32'h0000_0123, 1);
    build(1);
    trigger();
    wait_idle("R8");

    // R9: errors on status read and status write
    scen = "R9";
    add_rsp(32'h0000_0008, 0); add_rsp(0, 0);
    add_rsp(0, 1);
    add_rsp(0, 0); add_rsp(32'h0001_0000, 0); add_rsp(0, 1);
    add_rsp(0, 0); add_rsp(32'h0000_0001, 0); add_rsp(0, 0);
    add_rsp(32'h0, 0);
    build(1);
    trigger();
    wait_idle("R9");

    // R10: two edges during one slow access give one extra pass
    scen = "R10";
    lat = 8;
    add_rsp(32'h0000_0100, 0); add_rsp(0, 0); add_rsp(32'h0, 0);
    add_rsp(32'h0, 0);
    build(2);
    trigger();
    while (!busy) @(negedge clk);
    irq_n = 1'b1; @(negedge clk);
    irq_n = 1'b0; @(negedge clk);
    irq_n = 1'b1; @(negedge clk);
    irq_n = 1'b0;
    wait_idle("R10");
    lat = 1;

    // R2: rising edge and steady level start nothing
    scen = "R2";
    irq_n = 1'b1;
    wait_idle("R2");

    summary();
  end
endmodule